// File: doc/BRIEF.md
# Serial Divider Programming Port

This block is the configuration entry point of a frequency synthesizer. A host microcontroller drives three slow wires: a serial clock, a serial data line and a latch strobe. Every rising edge of the serial clock pushes one data bit into a 17-bit frame register, most significant bit first, so the last bit sent is frame bit 0. A rising edge on the strobe commits the frame. Frame bit 0 picks the destination. When it is 0, the upper sixteen bits become the feedback divide value. When it is 1, the upper fourteen bits become the reference divide value, and two control flags come from the bits below them.

All three wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are found on the synchronized copies. The serial link has no valid/ready handshake and cannot be stalled. The host meets the timing by holding data steady around each serial clock edge and by finishing the last clock pulse before it raises the strobe. A one-cycle pulse reports each commit and tells which holding register took it.

Top module: `synth_cfg_port`

## Requirements
- R1: While rst_n is low and on the first cycle after it, n_div_o, r_div_o, pre_sel_o, gate_o, ld_n_o and ld_r_o are all 0.
- R2: Each rising edge of sclk_i shifts sdata_i into frame bit 0 and moves every other frame bit up by one. Falling edges shift nothing, so bits sent MSB first end with the first bit in frame bit 16.
- R3: On a strobe with frame bit 0 = 0, frame bits 16..1 are loaded into n_div_o.
- R4: On a strobe with frame bit 0 = 1, frame bits 16..3 are loaded into r_div_o, frame bit 2 into pre_sel_o (1 = reference taken without the divide-by-4 stage) and frame bit 1 into gate_o (1 = synthesizer monitor outputs forced low).
- R5: The held outputs change only on a rising edge of sen_i. Serial shifting, and a strobe that stays high, change nothing.
- R6: A commit to one holding register leaves the other register and its flags unchanged.
- R7: Each strobe rising edge gives exactly one single-cycle pulse, on ld_n_o for an N commit or on ld_r_o for an R commit. The two pulses are never high together.
- R8: If other than 17 bits are shifted before the strobe, the frame holds the last 17 bits shifted in, including bits left over from earlier frames.
- R9: New held values are visible on the outputs after the third rising edge of clk following the rising edge of sen_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Asynchronous serial shift clock |
| sdata_i | input | 1 | Asynchronous serial data, MSB first |
| sen_i | input | 1 | Asynchronous commit strobe, active on rising edge |
| n_div_o | output | 16 | Held feedback divide value |
| r_div_o | output | 14 | Held reference divide value |
| pre_sel_o | output | 1 | Held reference prescale select flag |
| gate_o | output | 1 | Held monitor output gating flag |
| ld_n_o | output | 1 | One-cycle pulse on an N commit |
| ld_r_o | output | 1 | One-cycle pulse on an R commit |

## Verification
The bench uses the default widths: a 16-bit N field, a 14-bit R field and a 17-bit frame with two synchronizer stages. With these widths, frames of all-ones and all-zeros and short and long bursts put every field edge and the frame-leftover behaviour in reach. The two-stage synchronizer sets the three-cycle commit latency that the bench samples against. Random frames with random mode bits switch between the two layouts, so the bench can confirm that each commit leaves the other register alone.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned DEF_N_W = 16;
  localparam int unsigned DEF_R_W = 14;
  localparam int unsigned DEF_SYNC = 2;

  typedef enum logic {
    DEST_FEEDBACK  = 1'b0,
    DEST_REFERENCE = 1'b1
  } dest_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdata_s,
  output logic [FRAME_W-1:0] frame
);
  logic sclk_q;
  logic shift_en;

  assign shift_en = sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      frame  <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (shift_en) frame <= {frame[FRAME_W-2:0], sdata_s};
    end
  end
endmodule

// File: rtl/cfg_holding.sv
module cfg_holding
  import synth_cfg_pkg::*;
#(
  parameter int unsigned N_W = 16,
  parameter int unsigned R_W = 14,
  localparam int unsigned FRAME_W = N_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sen_s,
  input  logic [FRAME_W-1:0] frame,
  output logic [N_W-1:0]     n_div,
  output logic [R_W-1:0]     r_div,
  output logic               pre_sel,
  output logic               gate,
  output logic               ld_n,
  output logic               ld_r
);
  localparam int unsigned R_LSB = FRAME_W - R_W;

  logic  sen_q;
  logic  commit;
  dest_e dest;

  assign commit = sen_s & ~sen_q;
  assign dest   = dest_e'(frame[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sen_q   <= 1'b0;
      n_div   <= '0;
      r_div   <= '0;
      pre_sel <= 1'b0;
      gate    <= 1'b0;
      ld_n    <= 1'b0;
      ld_r    <= 1'b0;
    end else begin
      sen_q <= sen_s;
      ld_n  <= 1'b0;
      ld_r  <= 1'b0;
      if (commit) begin
        if (dest == DEST_FEEDBACK) begin
          n_div <= frame[FRAME_W-1:1];
          ld_n  <= 1'b1;
        end else begin
          r_div   <= frame[FRAME_W-1:R_LSB];
          pre_sel <= frame[2];
          gate    <= frame[1];
          ld_r    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int unsigned N_W   = DEF_N_W,
  parameter int unsigned R_W   = DEF_R_W,
  parameter int unsigned SYNC  = DEF_SYNC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sen_i,
  output logic [N_W-1:0] n_div_o,
  output logic [R_W-1:0] r_div_o,
  output logic           pre_sel_o,
  output logic           gate_o,
  output logic           ld_n_o,
  output logic           ld_r_o
);
  localparam int unsigned FRAME_W = N_W + 1;

  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] frame;

  cfg_sync #(.W(3), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sen_i, sdata_i, sclk_i}),
    .q     (pins_s)
  );

  cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[0]),
    .sdata_s (pins_s[1]),
    .frame   (frame)
  );

  cfg_holding #(.N_W(N_W), .R_W(R_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .sen_s   (pins_s[2]),
    .frame   (frame),
    .n_div   (n_div_o),
    .r_div   (r_div_o),
    .pre_sel (pre_sel_o),
    .gate    (gate_o),
    .ld_n    (ld_n_o),
    .ld_r    (ld_r_o)
  );
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
  parameter int unsigned N_W = 16,
  parameter int unsigned R_W = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N_W-1:0] n_div_o,
  input logic [R_W-1:0] r_div_o,
  input logic           pre_sel_o,
  input logic           gate_o,
  input logic           ld_n_o,
  input logic           ld_r_o
);
  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (n_div_o == '0 && r_div_o == '0 && !pre_sel_o && !gate_o && !ld_n_o && !ld_r_o));

  // R7
  p_single_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_n_o && ld_r_o));

  p_n_pulse_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n_o |=> !ld_n_o);

  p_r_pulse_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_r_o |=> !ld_r_o);

  // R5, R6
  p_n_only_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_div_o) |-> ld_n_o);

  p_r_only_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({r_div_o, pre_sel_o, gate_o}) |-> ld_r_o);
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.N_W(N_W), .R_W(R_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .n_div_o   (n_div_o),
  .r_div_o   (r_div_o),
  .pre_sel_o (pre_sel_o),
  .gate_o    (gate_o),
  .ld_n_o    (ld_n_o),
  .ld_r_o    (ld_r_o)
);

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, sen_i = 1'b0;
  logic [15:0] n_div_o;
  logic [13:0] r_div_o;
  logic pre_sel_o, gate_o, ld_n_o, ld_r_o;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int pulses_n = 0, pulses_r = 0, both_hi = 0;
  logic [16:0] fm = '0;
  logic [15:0] exp_n = '0;
  logic [13:0] exp_r = '0;
  logic exp_pre = 1'b0, exp_gate = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_cfg_port u_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i), .sen_i(sen_i),
    .n_div_o(n_div_o), .r_div_o(r_div_o), .pre_sel_o(pre_sel_o), .gate_o(gate_o),
    .ld_n_o(ld_n_o), .ld_r_o(ld_r_o)
  );

  always @(negedge clk) begin
    if (ld_n_o) pulses_n++;
    if (ld_r_o) pulses_r++;
    if (ld_n_o && ld_r_o) both_hi++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic send(logic [31:0] v, int cnt);
    for (int i = cnt - 1; i >= 0; i--) begin
      sdata_i = v[i];
      idle(3); sclk_i = 1'b1;
      idle(3); sclk_i = 1'b0;
      idle(3);
      fm = {fm[15:0], v[i]};
    end
  endtask

  task automatic check_held(string req);
    check({req, " n"}, 32'(n_div_o), 32'(exp_n));
    check({req, " r"}, 32'(r_div_o), 32'(exp_r));
    check({req, " flags"}, {30'd0, pre_sel_o, gate_o}, {30'd0, exp_pre, exp_gate});
  endtask

  task automatic strobe(string req);
    int pn, pr;
    pn = pulses_n; pr = pulses_r;
    sen_i = 1'b1;
    if (fm[0] == 1'b0) exp_n = fm[16:1];
    else begin
      exp_r = fm[16:3]; exp_pre = fm[2]; exp_gate = fm[1];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_held({req, " R9 latency"});
    idle(6);
    check_held({req, " R5 held with strobe high"});
    sen_i = 1'b0;
    idle(6);
    check({req, " R7 n pulses"}, 32'(pulses_n - pn), (fm[0] == 1'b0) ? 32'd1 : 32'd0);
    check({req, " R7 r pulses"}, 32'(pulses_r - pr), (fm[0] == 1'b1) ? 32'd1 : 32'd0);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    idle(4);
    check("R1 reset n", 32'(n_div_o), 0);
    check("R1 reset r", 32'(r_div_o), 0);
    check("R1 reset flags", {30'd0, pre_sel_o, gate_o}, 0);
    rst_n = 1'b1;
    idle(1);
    check("R1 after reset pulses", 32'(pulses_n + pulses_r), 0);

    // R3: all-ones N frame
    send(32'h1FFFE, 17); strobe("R3 all ones N");
    // R4: R frame with both flags set and alternating data
    send({15'd0, 14'h2AAA, 1'b1, 1'b1, 1'b1}, 17); strobe("R4 R with flags R6");
    // R2: MSB-first ordering
    send({15'd0, 16'h8001, 1'b0}, 17); strobe("R2 MSB first N R6");
    // R5: shifting without strobe changes nothing
    send(32'h1FFFF, 17); idle(8); check_held("R5 shift only");
    // R8: short burst keeps older bits
    send(32'h0, 5); strobe("R8 short burst");
    // R8: long burst keeps the last 17 bits
    send(32'h3F0F0, 22); strobe("R8 long burst");
    // R4: all-zero R frame clears flags
    send(32'h00001, 17); strobe("R4 zero R");

    for (int k = 0; k < 30; k++) begin
      int len;
      logic [31:0] v;
      len = ((k % 5) == 4) ? 12 + int'($urandom_range(10)) : 17;
      v = $urandom;
      send(v, len);
      strobe((fm[0]) ? "R4 random R6" : "R3 random R6");
    end

    check("R7 never both pulses", 32'(both_hi), 0);
    finish_run();
  end
endmodule